// File: doc/BRIEF.md
# Optical Black Clamp Loop

This block trims the black level of a 12-bit pixel stream in the digital domain. A clamp strobe marks the shielded pixels at the start of each line. During that window the block measures how far each corrected pixel sits from a programmable 8-bit black target. When the window closes, it averages those errors and feeds a scaled-down fraction of the average into a signed offset register. Every pixel the block emits has that offset added and is clipped to the unsigned 12-bit range. The loop behaves as a first-order low-pass filter and is updated once per line.

A blanking strobe zeroes the output. When both strobes are active, the clamp strobe wins. One polarity input sets whether the two strobes are active high or active low. When the loop enable is low, the offset register is frozen and the output carries the pixel plus the black target as a fixed offset.

The loop is sequenced by a three-state controller:
- `OBC_IDLE` moves to `OBC_ACCUM` when the clamp is active and the loop is enabled. This transition is named *open*.
- `OBC_ACCUM` moves to `OBC_UPDATE` on the first cycle the clamp is inactive. This transition is named *close*.
- `OBC_ACCUM` returns to `OBC_IDLE` if the enable drops. This transition is named *abort*.
- `OBC_UPDATE` always returns to `OBC_IDLE` one cycle later. This transition is named *retire*.

Top module: `ob_clamp_loop`

## Requirements
- R1: In reset, `out_vld` and `pix_out` are 0 and the offset register is 0. With the loop enabled and no window run yet, a pixel passes through unchanged.
- R2: `out_vld` is `pix_vld` delayed by one clock. The result for a valid input pixel appears on `pix_out` one clock after it is sampled.
- R3: With the loop enabled, `pix_out` = clip(pix_in + offset) to the range 0..4095.
- R4: For each valid pixel in a clamp window, the error is (pix_in + offset) − target. The window mean is taken over the first 2^m valid samples, with m = min(floor(log2 n), AVG_LG) and n the number of valid samples. Cycles with `pix_vld` low are not counted.
- R5: The offset changes only in `OBC_UPDATE`, one clock after the first clamp-inactive cycle. Its new value is offset − (mean >>> SHIFT), using arithmetic shifts, held within ±4095. Pixels sampled two or more clocks after that first inactive cycle see the new value.
- R6: When blanking is active and clamp is not, the valid output pixel is 0.
- R7: When clamp and blanking are both active, the output is the corrected pixel and the window is measured normally.
- R8: With `strb_pol` = 0 both strobes are active low. With `strb_pol` = 1 both are active high.
- R9: With `loop_en` low, `pix_out` = clip(pix_in + target), the offset holds, and clamp windows leave it untouched. A window whose enable drops before it closes is discarded.
- R10: A clamp window that contains no valid pixel leaves the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_in | input | 12 | Incoming pixel sample |
| pix_vld | input | 1 | Qualifies `pix_in` |
| clamp_strb | input | 1 | Optical-black window strobe, polarity per `strb_pol` |
| blank_strb | input | 1 | Blanking strobe, polarity per `strb_pol` |
| strb_pol | input | 1 | 1 = strobes active high, 0 = active low |
| loop_en | input | 1 | Enables the correction loop |
| ref_lvl | input | 8 | Black target in LSB |
| pix_out | output | 12 | Corrected, clipped pixel |
| out_vld | output | 1 | Qualifies `pix_out` |

## Verification
The bench builds the block with AVG_LG = 2 and SHIFT = 1. With these values, windows of 2, 3, 4 and 8 pixels exercise each averaging depth, including the cap at four samples. A single window moves the offset by half its mean, so the expected values stay small integers that are easy to compute. They still reach both output clip limits and the rounding of the arithmetic shift on negative steps.

// File: rtl/obc_pkg.sv
package obc_pkg;

    typedef enum logic [1:0] {
        OBC_IDLE   = 2'd0,
        OBC_ACCUM  = 2'd1,
        OBC_UPDATE = 2'd2
    } obc_state_e;

    function automatic logic signed [31:0] clip_s(
        input logic signed [31:0] v,
        input logic signed [31:0] lo,
        input logic signed [31:0] hi
    );
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/obc_strobe.sv
module obc_strobe #(
    parameter int N_STRB = 2
) (
    input  logic [N_STRB-1:0] strb_raw,
    input  logic              pol_high,
    output logic [N_STRB-1:0] strb_act
);
    for (genvar gi = 0; gi < N_STRB; gi++) begin : g_pol
        assign strb_act[gi] = pol_high ? strb_raw[gi] : ~strb_raw[gi];
    end
endmodule

// File: rtl/obc_err_acc.sv
module obc_err_acc
    import obc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int REF_W  = 8,
    parameter int OFS_W  = 14,
    parameter int AVG_LG = 4,
    parameter int SHIFT  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    loop_en,
    input  logic                    clamp_act,
    input  logic                    pix_vld,
    input  logic [DATA_W-1:0]       pix_in,
    input  logic [REF_W-1:0]        ref_lvl,
    output logic signed [OFS_W-1:0] ofs_q,
    output obc_state_e              state_q
);
    localparam int CORR_W  = OFS_W + 1;
    localparam int ERR_W   = CORR_W + 1;
    localparam int SUM_W   = ERR_W + AVG_LG;
    localparam int CNT_W   = AVG_LG + 1;
    localparam int LG_W    = (AVG_LG > 0) ? $clog2(AVG_LG + 1) : 1;
    localparam int CNT_LIM = 2 ** AVG_LG;
    localparam int OFS_MAX = 2 ** DATA_W - 1;

    obc_state_e state_d;

    logic signed [CORR_W-1:0] corr;
    logic signed [ERR_W-1:0]  err;
    logic signed [SUM_W-1:0]  err_ext, base_sum, nxt_sum, sum_q, snap_q, mean, step;
    logic [CNT_W-1:0]         base_cnt, nxt_cnt, cnt_q;
    logic [LG_W-1:0]          nxt_lg, snap_lg_q;
    logic                     has_q, start, take, pow2;
    logic signed [31:0]       upd_w;
    logic signed [OFS_W-1:0]  ofs_nxt;

    // error of the corrected sample against the target
    assign corr    = $signed({{(CORR_W-DATA_W){1'b0}}, pix_in}) + $signed({ofs_q[OFS_W-1], ofs_q});
    assign err     = $signed({corr[CORR_W-1], corr}) - $signed({{(ERR_W-REF_W){1'b0}}, ref_lvl});
    assign err_ext = {{AVG_LG{err[ERR_W-1]}}, err};

    assign start    = (state_q == OBC_IDLE) && clamp_act && loop_en;
    assign base_sum = start ? '0 : sum_q;
    assign base_cnt = start ? '0 : cnt_q;
    assign take     = pix_vld && clamp_act && loop_en && (state_q != OBC_UPDATE)
                      && (base_cnt != CNT_W'(CNT_LIM));
    assign nxt_cnt  = base_cnt + 1'b1;
    assign nxt_sum  = base_sum + err_ext;
    assign pow2     = (nxt_cnt & (nxt_cnt - 1'b1)) == '0;

    always_comb begin
        nxt_lg = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (nxt_cnt[i]) nxt_lg = LG_W'(i);
        end
    end

    // filter step: mean of the power-of-two prefix, then scaled down
    assign mean    = snap_q >>> snap_lg_q;
    assign step    = mean >>> SHIFT;
    assign upd_w   = 32'(ofs_q) - 32'(step);
    assign ofs_nxt = OFS_W'(clip_s(upd_w, -OFS_MAX, OFS_MAX));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OBC_IDLE:   if (clamp_act && loop_en) state_d = OBC_ACCUM;
            OBC_ACCUM:  if (!loop_en)             state_d = OBC_IDLE;
                        else if (!clamp_act)      state_d = OBC_UPDATE;
            OBC_UPDATE:                           state_d = OBC_IDLE;
            default:                              state_d = OBC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OBC_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers driven by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q     <= '0;
            cnt_q     <= '0;
            snap_q    <= '0;
            snap_lg_q <= '0;
            has_q     <= 1'b0;
            ofs_q     <= '0;
        end else begin
            if (start) begin
                sum_q <= '0;
                cnt_q <= '0;
                has_q <= 1'b0;
            end
            if (take) begin
                sum_q <= nxt_sum;
                cnt_q <= nxt_cnt;
                if (pow2) begin
                    snap_q    <= nxt_sum;
                    snap_lg_q <= nxt_lg;
                    has_q     <= 1'b1;
                end
            end
            if ((state_q == OBC_UPDATE) && loop_en && has_q) ofs_q <= ofs_nxt;
        end
    end
endmodule

// File: rtl/obc_out_stage.sv
module obc_out_stage
    import obc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int REF_W  = 8,
    parameter int OFS_W  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W-1:0]       pix_in,
    input  logic                    pix_vld,
    input  logic                    loop_en,
    input  logic                    blank_eff,
    input  logic signed [OFS_W-1:0] ofs,
    input  logic [REF_W-1:0]        ref_lvl,
    output logic [DATA_W-1:0]       pix_out,
    output logic                    out_vld
);
    localparam int PIX_MAX = 2 ** DATA_W - 1;

    logic signed [31:0] adj, sumv;

    assign adj  = loop_en ? 32'(ofs) : $signed(32'(ref_lvl));
    assign sumv = $signed(32'(pix_in)) + adj;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_out <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= pix_vld;
            if (pix_vld) pix_out <= blank_eff ? '0 : DATA_W'(clip_s(sumv, 0, PIX_MAX));
        end
    end
endmodule

// File: rtl/ob_clamp_loop.sv
module ob_clamp_loop
    import obc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int REF_W  = 8,
    parameter int OFS_W  = 14,
    parameter int AVG_LG = 4,
    parameter int SHIFT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_in,
    input  logic              pix_vld,
    input  logic              clamp_strb,
    input  logic              blank_strb,
    input  logic              strb_pol,
    input  logic              loop_en,
    input  logic [REF_W-1:0]  ref_lvl,
    output logic [DATA_W-1:0] pix_out,
    output logic              out_vld
);
    logic [1:0]              strb_act;
    logic                    clamp_act, blank_eff;
    logic signed [OFS_W-1:0] ofs_q;
    obc_state_e              state_q;

    obc_strobe #(.N_STRB(2)) u_strb (
        .strb_raw ({blank_strb, clamp_strb}),
        .pol_high (strb_pol),
        .strb_act (strb_act)
    );

    assign clamp_act = strb_act[0];
    assign blank_eff = strb_act[1] & ~clamp_act;  // clamp has priority

    obc_err_acc #(
        .DATA_W(DATA_W), .REF_W(REF_W), .OFS_W(OFS_W), .AVG_LG(AVG_LG), .SHIFT(SHIFT)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .loop_en   (loop_en),
        .clamp_act (clamp_act),
        .pix_vld   (pix_vld),
        .pix_in    (pix_in),
        .ref_lvl   (ref_lvl),
        .ofs_q     (ofs_q),
        .state_q   (state_q)
    );

    obc_out_stage #(.DATA_W(DATA_W), .REF_W(REF_W), .OFS_W(OFS_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_in    (pix_in),
        .pix_vld   (pix_vld),
        .loop_en   (loop_en),
        .blank_eff (blank_eff),
        .ofs       (ofs_q),
        .ref_lvl   (ref_lvl),
        .pix_out   (pix_out),
        .out_vld   (out_vld)
    );
endmodule

// File: rtl/obc_checker.sv
module obc_checker
    import obc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int OFS_W  = 14
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pix_vld,
    input logic                    out_vld,
    input logic [DATA_W-1:0]       pix_out,
    input logic                    clamp_strb,
    input logic                    blank_strb,
    input logic                    strb_pol,
    input logic                    loop_en,
    input logic signed [OFS_W-1:0] ofs,
    input obc_state_e              state
);
    localparam int OFS_MAX = 2 ** DATA_W - 1;

    logic clamp_on, blank_on;
    assign clamp_on = strb_pol ? clamp_strb : !clamp_strb;
    assign blank_on = strb_pol ? blank_strb : !blank_strb;

    assert_vld_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> out_vld);
    assert_vld_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |=> !out_vld);
    assert_blank_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && blank_on && !clamp_on) |=> (pix_out == '0));
    assert_ofs_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ofs) <= OFS_MAX) && (int'(ofs) >= -OFS_MAX));
    assert_ofs_only_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != OBC_UPDATE) |=> $stable(ofs));
    assert_update_after_accum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OBC_UPDATE) |-> ($past(state) == OBC_ACCUM));
    assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> $stable(ofs));
endmodule

bind ob_clamp_loop obc_checker #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_vld    (pix_vld),
    .out_vld    (out_vld),
    .pix_out    (pix_out),
    .clamp_strb (clamp_strb),
    .blank_strb (blank_strb),
    .strb_pol   (strb_pol),
    .loop_en    (loop_en),
    .ofs        (ofs_q),
    .state      (state_q)
);

// File: tb/ob_clamp_loop_test.sv
module ob_clamp_loop_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pix_in = '0;
    logic        pix_vld = 1'b0;
    logic        clamp_strb = 1'b0;
    logic        blank_strb = 1'b0;
    logic        strb_pol = 1'b1;
    logic        loop_en = 1'b1;
    logic [7:0]  ref_lvl = 8'd128;
    logic [11:0] pix_out;
    logic        out_vld;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    ob_clamp_loop #(.AVG_LG(2), .SHIFT(1)) uut (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .pix_vld(pix_vld),
        .clamp_strb(clamp_strb), .blank_strb(blank_strb), .strb_pol(strb_pol),
        .loop_en(loop_en), .ref_lvl(ref_lvl), .pix_out(pix_out), .out_vld(out_vld)
    );

    // {target, black pixel, window length, test pixel, expected}
    localparam int NV = 5;
    localparam logic [51:0] VECS [NV] = '{
        {8'd128, 12'd200, 8'd4, 12'd1000, 12'd964},
        {8'd100, 12'd20,  8'd8, 12'd4080, 12'd4095},
        {8'd0,   12'd300, 8'd3, 12'd100,  12'd0},
        {8'd50,  12'd53,  8'd2, 12'd500,  12'd499},
        {8'd50,  12'd47,  8'd2, 12'd500,  12'd502}
    };

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic px(input logic [11:0] v, input logic vld, input logic c, input logic b);
        pix_in     = v;
        pix_vld    = vld;
        clamp_strb = strb_pol ? c : ~c;
        blank_strb = strb_pol ? b : ~b;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) px(12'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic window(input logic [11:0] v, input int n);
        for (int i = 0; i < n; i++) px(v, 1'b1, 1'b1, 1'b0);
        idle(3);
    endtask

    task automatic check_pix(input logic [11:0] v, input logic [11:0] exp, input string tag);
        px(v, 1'b1, 1'b0, 1'b0);
        chk(pix_out, exp, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        chk(out_vld, 0, "R1 out_vld in reset");
        chk(pix_out, 0, "R1 pix_out in reset");
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // table of windows, each from a fresh offset (R4, R5, R3)
        for (int k = 0; k < NV; k++) begin
            strb_pol = 1'b1;
            loop_en  = 1'b1;
            do_reset();
            ref_lvl = VECS[k][51:44];
            window(VECS[k][43:32], int'(VECS[k][31:24]));
            check_pix(VECS[k][23:12], VECS[k][11:0], "R4 R5 R3 table vector");
        end

        // R1: pass-through right after reset
        do_reset();
        check_pix(12'd777, 12'd777, "R1 zero offset after reset");

        // R2: valid follows one clock later
        px(12'd321, 1'b1, 1'b0, 1'b0);
        chk(out_vld, 1, "R2 out_vld high");
        chk(pix_out, 321, "R2 data");
        px(12'd5, 1'b0, 1'b0, 1'b0);
        chk(out_vld, 0, "R2 out_vld low");

        // R6: blanking zeroes output
        px(12'd500, 1'b1, 1'b0, 1'b1);
        chk(pix_out, 0, "R6 blank forces zero");
        check_pix(12'd500, 12'd500, "R6 blank released");

        // R7: clamp with blanking overlapping
        do_reset();
        ref_lvl = 8'd128;
        px(12'd200, 1'b1, 1'b1, 1'b1);
        px(12'd200, 1'b1, 1'b1, 1'b1);
        chk(pix_out, 200, "R7 clamp beats blank");
        px(12'd200, 1'b1, 1'b1, 1'b1);
        px(12'd200, 1'b1, 1'b1, 1'b1);
        idle(3);
        check_pix(12'd1000, 12'd964, "R7 window measured under blank");

        // R5: second window filters further
        window(12'd200, 4);
        check_pix(12'd1000, 12'd946, "R5 second IIR step");

        // R8: active-low strobes
        strb_pol = 1'b0;
        do_reset();
        check_pix(12'd1000, 12'd1000, "R8 high levels inactive when active low");
        px(12'd600, 1'b1, 1'b0, 1'b1);
        chk(pix_out, 0, "R8 active-low blank");
        window(12'd200, 4);
        check_pix(12'd1000, 12'd964, "R8 active-low clamp");
        strb_pol = 1'b1;

        // R9: loop disabled
        do_reset();
        loop_en = 1'b0;
        ref_lvl = 8'd128;
        check_pix(12'd1000, 12'd1128, "R9 fixed target offset");
        ref_lvl = 8'd200;
        check_pix(12'd4000, 12'd4095, "R9 fixed offset clipped");
        ref_lvl = 8'd128;
        window(12'd200, 4);
        loop_en = 1'b1;
        idle(2);
        check_pix(12'd1000, 12'd1000, "R9 window ignored while disabled");
        px(12'd200, 1'b1, 1'b1, 1'b0);
        px(12'd200, 1'b1, 1'b1, 1'b0);
        loop_en = 1'b0;
        px(12'd200, 1'b1, 1'b1, 1'b0);
        px(12'd200, 1'b1, 1'b1, 1'b0);
        idle(3);
        loop_en = 1'b1;
        idle(3);
        check_pix(12'd1000, 12'd1000, "R9 aborted window discarded");

        // R4: invalid cycles skipped, only first four samples used
        do_reset();
        ref_lvl = 8'd128;
        for (int i = 0; i < 4; i++) begin
            px(12'd200, 1'b1, 1'b1, 1'b0);
            px(12'd4095, 1'b0, 1'b1, 1'b0);
        end
        idle(3);
        check_pix(12'd1000, 12'd964, "R4 invalid cycles skipped");
        do_reset();
        for (int i = 0; i < 4; i++) px(12'd200, 1'b1, 1'b1, 1'b0);
        px(12'd4095, 1'b1, 1'b1, 1'b0);
        px(12'd4095, 1'b1, 1'b1, 1'b0);
        idle(3);
        check_pix(12'd1000, 12'd964, "R4 samples beyond cap ignored");

        // R10: window with no valid pixels
        do_reset();
        for (int i = 0; i < 4; i++) px(12'd4095, 1'b0, 1'b1, 1'b0);
        idle(3);
        check_pix(12'd1000, 12'd1000, "R10 empty window");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule